// File: doc/BRIEF.md
# Scanned Multi-Line Transmit Arbiter

This block is the transmit side of an eight-line serial multiplexer that shares a single host data register across all of its lines. A scanner walks the lines in turn. It parks on the first line that is both enabled for transmit and able to take a character, which means that line's holding register is empty. While parked it raises a ready flag and presents the line number next to it. The host then writes one byte. That byte goes to the parked line, and the scanner moves on to look for the next line.

Each line is double buffered: a holding register feeds a shift stage. The shift stage is modelled only as a busy flag with the character it carries, and an external done pulse frees it. The host enables lines for scanning through a per-line enable byte. A master scan enable gates the whole scanner, and a transmit interrupt enable turns the ready flag into an interrupt. When a line has nothing more to send, the host clears its enable bit, and the scanner is released to serve other lines.

Top module: `tx_scan_arb`

## Requirements
- R1: After synchronous reset, `tx_ready` and `tx_irq` are 0, `tx_line` is 0 and no shift stage is busy.
- R2: When the scanner parks, `tx_ready` is 1 and `tx_line` names a line whose `line_en` bit (bit n for line n) is 1 and whose holding register is empty.
- R3: A `tx_wr` pulse while `tx_ready` is 1 loads `tx_data` into the parked line's holding register and clears `tx_ready` on the next cycle. One cycle after that, the character moves to that line's shift stage if the stage is idle.
- R4: If the parked line's `line_en` bit is cleared, `tx_ready` drops on the next cycle. With all enable bits clear, `tx_ready` stays 0.
- R5: A line whose holding register is full is never offered. After a written character has moved into an idle shift stage, the same line can be offered again. Once both stages are full, the line is offered only after a `sh_done` pulse frees the shift stage.
- R6: While `scan_en` is 0, `tx_ready` is 0. `tx_irq` is 1 exactly when `tx_ready` and `tx_irq_en` are both 1.
- R7: The scanner advances one line per clock in ascending order and wraps from line 7 to line 0. After serving a line, it resumes its search at the next line up, so enabled lines are served round-robin.
- R8: While parked, `tx_line` holds its value until a write occurs or the parked line's enable bit is cleared.
- R9: A `tx_wr` pulse while `tx_ready` is 0 changes no line's buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Master scan enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| line_en | input | 8 | Per-line transmit scan enable, bit n for line n |
| tx_wr | input | 1 | Host byte write strobe to the transmit buffer |
| tx_data | input | 8 | Character written by the host |
| sh_done | input | 8 | Per-line pulse: shift stage has finished its character |
| tx_ready | output | 1 | Scanner is parked on a line that can accept a character |
| tx_line | output | 3 | Line the scanner currently targets |
| tx_irq | output | 1 | Transmit interrupt |
| sh_busy | output | 8 | Per-line shift stage busy |
| sh_char | output | 64 | Per-line character in the shift stage, line n at bits 8n+7..8n |

## Verification
On every cycle, the assertions check the following: a parked line really has an empty holding register; a write always clears ready; at most one line is loaded per write; no line is loaded while its holding register is full; the scanner stays idle while the master enable is off; and the parked line number stays stable. Other properties need whole scenarios, so only the bench's directed tests can show them. These are the round-robin service order and the wrap from line 7 to line 0. They also include the double-buffer sequence, where a line is offered again after a write, then withheld once both stages are full, then released by a done pulse. Finally, they cover the fact that a stray write while not ready leaves every line's shift stage untouched.

// File: rtl/tx_scan_pkg.sv
package tx_scan_pkg;

    typedef enum logic {
        SC_SEEK = 1'b0,
        SC_PARK = 1'b1
    } scan_mode_e;

    typedef struct packed {
        logic       full;
        logic [7:0] data;
    } hold_slot_t;

    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/tx_line_buf.sv
module tx_line_buf
    import tx_scan_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          done,
    output logic          room,
    output logic          busy,
    output logic [DW-1:0] shift_char
);
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          move;

    assign move = hold_full && (!busy || done);
    assign room = !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full  <= 1'b0;
            hold_data  <= '0;
            busy       <= 1'b0;
            shift_char <= '0;
        end else begin
            if (load) begin
                hold_full <= 1'b1;
                hold_data <= load_data;
            end else if (move) begin
                hold_full <= 1'b0;
            end
            if (move) begin
                busy       <= 1'b1;
                shift_char <= hold_data;
            end else if (done) begin
                busy <= 1'b0;
            end
        end
    end

    // R5
    load_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !hold_full);

    // R3
    move_fills_shift_chk: assert property (@(posedge clk) disable iff (rst)
        move |=> busy);

endmodule

// File: rtl/tx_scan_ctrl.sv
module tx_scan_ctrl
    import tx_scan_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic [NLINES-1:0] line_en,
    input  logic [NLINES-1:0] room,
    input  logic              wr,
    output logic              ready,
    output logic [LW-1:0]     ptr,
    output logic [NLINES-1:0] load_sel
);
    scan_mode_e mode;
    logic [LW-1:0] ptr_inc;

    assign ready   = (mode == SC_PARK);
    assign ptr_inc = LW'(wrap_next(int'(ptr), NLINES));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= SC_SEEK;
            ptr  <= '0;
        end else if (!scan_en) begin
            mode <= SC_SEEK;
        end else if (mode == SC_PARK) begin
            if (wr || !line_en[ptr]) begin
                mode <= SC_SEEK;
                ptr  <= ptr_inc;
            end
        end else begin
            if (line_en[ptr] && room[ptr])
                mode <= SC_PARK;
            else
                ptr <= ptr_inc;
        end
    end

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_sel
            assign load_sel[g] = ready && wr && (ptr == LW'(g));
        end
    endgenerate

    // R3
    wr_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && wr) |=> !ready);

    // R3
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_sel));

    // R6
    scan_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> !ready);

    // R8
    parked_line_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !wr && line_en[ptr] && scan_en) |=> (ready && $stable(ptr)));

    // R4
    disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !line_en[ptr]) |=> !ready);

endmodule

// File: rtl/tx_scan_arb.sv
module tx_scan_arb
    import tx_scan_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DW = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic                 tx_irq_en,
    input  logic [NLINES-1:0]    line_en,
    input  logic                 tx_wr,
    input  logic [DW-1:0]        tx_data,
    input  logic [NLINES-1:0]    sh_done,
    output logic                 tx_ready,
    output logic [LW-1:0]        tx_line,
    output logic                 tx_irq,
    output logic [NLINES-1:0]    sh_busy,
    output logic [NLINES*DW-1:0] sh_char
);
    logic [NLINES-1:0] room;
    logic [NLINES-1:0] load_sel;

    tx_scan_ctrl #(.NLINES(NLINES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .line_en  (line_en),
        .room     (room),
        .wr       (tx_wr),
        .ready    (tx_ready),
        .ptr      (tx_line),
        .load_sel (load_sel)
    );

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            tx_line_buf #(.DW(DW)) u_buf (
                .clk        (clk),
                .rst        (rst),
                .load       (load_sel[g]),
                .load_data  (tx_data),
                .done       (sh_done[g]),
                .room       (room[g]),
                .busy       (sh_busy[g]),
                .shift_char (sh_char[g*DW +: DW])
            );
        end
    endgenerate

    assign tx_irq = tx_ready && tx_irq_en;

    // R2
    ready_room_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> room[tx_line]);

endmodule

// File: tb/tx_scan_arb_bench.sv
module tx_scan_arb_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        scan_en;
    logic        tx_irq_en;
    logic [7:0]  line_en;
    logic        tx_wr;
    logic [7:0]  tx_data;
    logic [7:0]  sh_done;
    logic        tx_ready;
    logic [2:0]  tx_line;
    logic        tx_irq;
    logic [7:0]  sh_busy;
    logic [63:0] sh_char;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_scan_arb u_tx_scan_arb (
        .clk(clk), .rst(rst), .scan_en(scan_en), .tx_irq_en(tx_irq_en),
        .line_en(line_en), .tx_wr(tx_wr), .tx_data(tx_data), .sh_done(sh_done),
        .tx_ready(tx_ready), .tx_line(tx_line), .tx_irq(tx_irq),
        .sh_busy(sh_busy), .sh_char(sh_char)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scan_en = 1'b0; tx_irq_en = 1'b0; line_en = '0;
        tx_wr = 1'b0; tx_data = '0; sh_done = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_ready(output bit got);
        got = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_ready) begin got = 1; break; end
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic serve_expect(input string req, input int line);
        bit got;
        wait_ready(got);
        check(req, int'(got), 1);
        check(req, int'(tx_line), line);
        host_write(8'h40 + 8'(line));
    endtask

    task automatic t_reset();
        do_reset();
        // R1
        check("R1", int'(tx_ready), 0);
        check("R1", int'(tx_irq), 0);
        check("R1", int'(tx_line), 0);
        check("R1", int'(sh_busy), 0);
    endtask

    task automatic t_single_and_double_buffer();
        bit got;
        do_reset();
        line_en = 8'b0000_0100; scan_en = 1'b1;
        wait_ready(got);
        // R2
        check("R2", int'(got), 1);
        check("R2", int'(tx_line), 2);
        // R6: irq off while enable low
        check("R6", int'(tx_irq), 0);
        tx_irq_en = 1'b1;
        #1;
        check("R6", int'(tx_irq), 1);
        host_write(8'h41);
        // R3: ready clears after the write
        check("R3", int'(tx_ready), 0);
        @(negedge clk);
        check("R3", int'(sh_busy[2]), 1);
        check("R3", int'(sh_char[23:16]), 8'h41);
        // R5: line offered again after its character moved to the shift stage
        wait_ready(got);
        check("R5", int'(got), 1);
        check("R5", int'(tx_line), 2);
        host_write(8'h42);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tx_ready) break;
        end
        check("R5", int'(tx_ready), 0);
        check("R5", int'(sh_char[23:16]), 8'h41);
        sh_done = 8'b0000_0100;
        @(negedge clk);
        sh_done = '0;
        check("R5", int'(sh_char[23:16]), 8'h42);
        check("R5", int'(sh_busy[2]), 1);
        wait_ready(got);
        check("R5", int'(got), 1);
    endtask

    task automatic t_round_robin();
        bit got;
        do_reset();
        line_en = 8'b0101_0010; scan_en = 1'b1;
        // R7: ascending order, resume after last served
        serve_expect("R7", 1);
        serve_expect("R7", 4);
        serve_expect("R7", 6);
        serve_expect("R7", 1);
        serve_expect("R7", 4);
        serve_expect("R7", 6);
        wait_ready(got);
        // R5: both stages full on every enabled line
        check("R5", int'(got), 0);
        check("R7", int'(sh_char[15:8]), 8'h41);
        check("R7", int'(sh_char[39:32]), 8'h44);
        check("R7", int'(sh_char[55:48]), 8'h46);
    endtask

    task automatic t_wrap();
        do_reset();
        line_en = 8'b1000_0001; scan_en = 1'b1;
        // R7: wrap from 7 to 0
        serve_expect("R7", 0);
        serve_expect("R7", 7);
        serve_expect("R7", 0);
        serve_expect("R7", 7);
    endtask

    task automatic t_park_and_release();
        bit got;
        do_reset();
        line_en = 8'b0010_0000; scan_en = 1'b1;
        wait_ready(got);
        check("R2", int'(tx_line), 5);
        // R8: stays parked and stable
        for (int i = 0; i < 10; i++) @(negedge clk);
        check("R8", int'(tx_ready), 1);
        check("R8", int'(tx_line), 5);
        line_en = '0;
        @(negedge clk);
        // R4
        check("R4", int'(tx_ready), 0);
        wait_ready(got);
        check("R4", int'(got), 0);
        // R9: stray write while not ready touches nothing
        host_write(8'h99);
        @(negedge clk);
        @(negedge clk);
        check("R9", int'(sh_busy), 0);
        check("R9", int'(sh_char), 0);
        line_en = 8'b0010_0000;
        wait_ready(got);
        host_write(8'h55);
        @(negedge clk);
        check("R9", int'(sh_char[47:40]), 8'h55);
    endtask

    task automatic t_scan_disabled();
        bit got;
        do_reset();
        line_en = 8'hFF; scan_en = 1'b0; tx_irq_en = 1'b1;
        wait_ready(got);
        // R6
        check("R6", int'(got), 0);
        check("R6", int'(tx_irq), 0);
        scan_en = 1'b1;
        wait_ready(got);
        check("R6", int'(got), 1);
        scan_en = 1'b0;
        @(negedge clk);
        check("R6", int'(tx_ready), 0);
    endtask

    initial begin
        rst = 1'b1; scan_en = 1'b0; tx_irq_en = 1'b0; line_en = '0;
        tx_wr = 1'b0; tx_data = '0; sh_done = '0;
        t_reset();
        t_single_and_double_buffer();
        t_round_robin();
        t_wrap();
        t_park_and_release();
        t_scan_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule